// File: doc/BRIEF.md
# Zigzag Scan Address Generator

This block is a data counter that visits every cell of a square pixel block in the diagonal zigzag order used for transform coefficients. A single start pulse launches a scan. The block then presents one coordinate pair per handshake on a valid/ready output. The pair is 1-based, with column first and row second, and a row-major linear address comes with it. A consumer such as a pixel memory or a coefficient reorder stage takes one address each time it raises ready. It may stall the stream at any cycle.

The scan is not read from a table. It is composed from four unit moves: east (+1,0), south (0,+1), south-west (-1,+1) and north-east (+1,-1). The diagonal moves repeat until an edge test on the next coordinate succeeds. The first half of the walk is one east move followed by (BLK/2-1) rounds of south-west, south, north-east and east. This half ends in the top-right corner. One south-west diagonal then crosses the block to the bottom-left corner. The second half is the first half turned 180 degrees about the block centre and played backwards. It is built from its own moves: (BLK/2-1) rounds of east, north-east until the right edge, south, and south-west until the bottom edge. A closing east move then reaches the bottom-right corner. Both halves reuse the same step logic.

The sequencer states are:
- ST_IDLE: waits for start.
- ST_A_EAST0: the first east move.
- ST_A_SW, ST_A_SOUTH, ST_A_NE and ST_A_EAST: one first-half round.
- ST_MID_SW: the crossing diagonal.
- ST_B_EAST, ST_B_NE, ST_B_SOUTH and ST_B_SW: one second-half round.
- ST_B_EAST_END: the closing east move.
- ST_TAIL: the final coordinate is on the output.

The transitions are:
- An accepted start moves ST_IDLE to ST_A_EAST0.
- A single-step state advances on every handshake.
- A diagonal state advances on the handshake whose next coordinate meets its edge test.
- ST_A_EAST and ST_B_SW either loop back, with the round count incremented, or leave once the last round is complete.
- ST_TAIL returns to ST_IDLE on its handshake.

Top module: `zz_scan_gen`

## Requirements
- R1: After reset, addr_valid, addr_last and scan_done are all low.
- R2: A scan_start while idle makes addr_valid high on the next cycle with column 1, row 1 and linear address 0.
- R3: For BLK=8 the 64 accepted coordinates follow the zigzag order. Index 0 is (1,1), index 1 is (2,1), index 2 is (1,2), index 3 is (1,3), index 28 is (8,1), index 35 is (1,8), index 36 is (2,8) and index 63 is (8,8). The full order is: for each anti-diagonal s = col+row-2 from 0 to 14, odd s runs with the column falling and even s runs with the row falling.
- R4: While addr_valid is high and addr_ready is low, the coordinate, the linear address and addr_last hold their values. The output advances only on a cycle where addr_valid and addr_ready are both high.
- R5: addr_lin equals (row-1)*BLK + (col-1).
- R6: addr_last is high exactly while the final coordinate (BLK,BLK) is presented.
- R7: scan_done is high for exactly one cycle, the cycle after the final handshake, and addr_valid is low in that cycle.
- R8: A scan_start received while a scan is in progress is ignored. The order continues unchanged.
- R9: Every presented coordinate lies in 1..BLK. Each handshake other than the last changes the coordinate.
- R10: No linear address repeats within one scan.
- R11: A new scan_start after scan_done begins a fresh scan at (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_start | input | 1 | Pulse that launches a scan when idle |
| addr_ready | input | 1 | Consumer accepts the presented address |
| addr_valid | output | 1 | An address is presented |
| addr_col | output | CW | Column, 1-based |
| addr_row | output | CW | Row, 1-based |
| addr_lin | output | AW | Row-major linear address |
| addr_last | output | 1 | Presented address is the final one |
| scan_done | output | 1 | One-cycle pulse after the final handshake |

## Verification
A wrong sequencer state or round count shows at the very next handshake. In that case the column or row departs from the zigzag order, so a per-index comparison catches it at the cycle it happens. A bad edge test lets a diagonal overshoot the block, which shows as an out-of-range coordinate. It can also stop a diagonal short, which shows as a repeated linear address or a wrong count before scan_done. Errors in the handshake path show as a coordinate that moves while ready is low. They also show as addr_last or scan_done appearing off the final index.

// File: rtl/zz_pkg.sv
package zz_pkg;

    // unit moves applied to the coordinate
    typedef enum logic [1:0] {
        MV_EAST,
        MV_SOUTH,
        MV_SW,
        MV_NE
    } move_e;

    // sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_EAST0,
        ST_A_SW,
        ST_A_SOUTH,
        ST_A_NE,
        ST_A_EAST,
        ST_MID_SW,
        ST_B_EAST,
        ST_B_NE,
        ST_B_SOUTH,
        ST_B_SW,
        ST_B_EAST_END,
        ST_TAIL
    } scan_st_e;

endpackage

// File: rtl/zz_step_unit.sv
module zz_step_unit
    import zz_pkg::*;
#(
    parameter int BLK = 8,
    parameter int CW  = $clog2(BLK + 1)
) (
    input  move_e         mv,
    input  logic [CW-1:0] cur_col,
    input  logic [CW-1:0] cur_row,
    output logic [CW-1:0] nxt_col,
    output logic [CW-1:0] nxt_row,
    output logic          hit_left,
    output logic          hit_top,
    output logic          hit_right,
    output logic          hit_bottom
);

    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] EDGE = CW'(BLK);

    always_comb begin
        nxt_col = cur_col;
        nxt_row = cur_row;
        unique case (mv)
            MV_EAST:  nxt_col = cur_col + ONE;
            MV_SOUTH: nxt_row = cur_row + ONE;
            MV_SW: begin
                nxt_col = cur_col - ONE;
                nxt_row = cur_row + ONE;
            end
            MV_NE: begin
                nxt_col = cur_col + ONE;
                nxt_row = cur_row - ONE;
            end
        endcase
    end

    // edge tests are made on the coordinate that the move produces
    assign hit_left   = (nxt_col == ONE);
    assign hit_top    = (nxt_row == ONE);
    assign hit_right  = (nxt_col == EDGE);
    assign hit_bottom = (nxt_row == EDGE);

endmodule

// File: rtl/zz_scan_fsm.sv
module zz_scan_fsm
    import zz_pkg::*;
#(
    parameter int REPS = 3,
    parameter int RW   = (REPS > 1) ? $clog2(REPS) : 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_ok,
    input  logic  adv,
    input  logic  hit_left,
    input  logic  hit_top,
    input  logic  hit_right,
    input  logic  hit_bottom,
    output move_e mv,
    output logic  idle,
    output logic  tail
);

    localparam logic [RW-1:0] REP_LAST = RW'(REPS - 1);

    scan_st_e      st_q, st_d;
    logic [RW-1:0] rep_q, rep_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            rep_q <= '0;
        end else begin
            st_q  <= st_d;
            rep_q <= rep_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        rep_d = rep_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_ok) begin
                    st_d  = ST_A_EAST0;
                    rep_d = '0;
                end
            end
            ST_A_EAST0: if (adv) st_d = ST_A_SW;
            ST_A_SW:    if (adv && hit_left) st_d = ST_A_SOUTH;
            ST_A_SOUTH: if (adv) st_d = ST_A_NE;
            ST_A_NE:    if (adv && hit_top) st_d = ST_A_EAST;
            ST_A_EAST: begin
                if (adv) begin
                    if (rep_q == REP_LAST) begin
                        st_d  = ST_MID_SW;
                        rep_d = '0;
                    end else begin
                        st_d  = ST_A_SW;
                        rep_d = rep_q + RW'(1);
                    end
                end
            end
            ST_MID_SW:  if (adv && hit_left) st_d = ST_B_EAST;
            ST_B_EAST:  if (adv) st_d = ST_B_NE;
            ST_B_NE:    if (adv && hit_right) st_d = ST_B_SOUTH;
            ST_B_SOUTH: if (adv) st_d = ST_B_SW;
            ST_B_SW: begin
                if (adv && hit_bottom) begin
                    if (rep_q == REP_LAST) begin
                        st_d = ST_B_EAST_END;
                    end else begin
                        st_d  = ST_B_EAST;
                        rep_d = rep_q + RW'(1);
                    end
                end
            end
            ST_B_EAST_END: if (adv) st_d = ST_TAIL;
            ST_TAIL:       if (adv) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mv   = MV_EAST;
        idle = 1'b0;
        tail = 1'b0;
        unique case (st_q)
            ST_IDLE:       idle = 1'b1;
            ST_A_EAST0:    mv = MV_EAST;
            ST_A_SW:       mv = MV_SW;
            ST_A_SOUTH:    mv = MV_SOUTH;
            ST_A_NE:       mv = MV_NE;
            ST_A_EAST:     mv = MV_EAST;
            ST_MID_SW:     mv = MV_SW;
            ST_B_EAST:     mv = MV_EAST;
            ST_B_NE:       mv = MV_NE;
            ST_B_SOUTH:    mv = MV_SOUTH;
            ST_B_SW:       mv = MV_SW;
            ST_B_EAST_END: mv = MV_EAST;
            ST_TAIL:       tail = 1'b1;
            default:       idle = 1'b0;
        endcase
    end

endmodule

// File: rtl/zz_lin_addr.sv
module zz_lin_addr #(
    parameter int BLK = 8,
    parameter int CW  = $clog2(BLK + 1),
    parameter int AW  = $clog2(BLK * BLK)
) (
    input  logic [CW-1:0] col,
    input  logic [CW-1:0] row,
    output logic [AW-1:0] lin
);

    localparam int LW = $clog2(BLK);

    logic [AW-1:0] c0, r0;

    assign c0 = AW'(col) - AW'(1);
    assign r0 = AW'(row) - AW'(1);

    generate
        if ((BLK & (BLK - 1)) == 0) begin : g_pow2
            assign lin = (r0 << LW) + c0;
        end else begin : g_mult
            assign lin = (r0 * AW'(BLK)) + c0;
        end
    endgenerate

endmodule

// File: rtl/zz_scan_gen.sv
module zz_scan_gen
    import zz_pkg::*;
#(
    parameter int BLK = 8,
    parameter int CW  = $clog2(BLK + 1),
    parameter int AW  = $clog2(BLK * BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_start,
    input  logic          addr_ready,
    output logic          addr_valid,
    output logic [CW-1:0] addr_col,
    output logic [CW-1:0] addr_row,
    output logic [AW-1:0] addr_lin,
    output logic          addr_last,
    output logic          scan_done
);

    localparam int REPS = BLK / 2 - 1;

    move_e         mv;
    logic          idle, tail, start_ok, adv;
    logic          hit_left, hit_top, hit_right, hit_bottom;
    logic [CW-1:0] col_q, row_q, nxt_col, nxt_row;
    logic          valid_q, done_q;

    assign start_ok = scan_start && idle;
    assign adv      = valid_q && addr_ready;

    zz_scan_fsm #(.REPS(REPS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .adv        (adv),
        .hit_left   (hit_left),
        .hit_top    (hit_top),
        .hit_right  (hit_right),
        .hit_bottom (hit_bottom),
        .mv         (mv),
        .idle       (idle),
        .tail       (tail)
    );

    zz_step_unit #(.BLK(BLK), .CW(CW)) u_step (
        .mv         (mv),
        .cur_col    (col_q),
        .cur_row    (row_q),
        .nxt_col    (nxt_col),
        .nxt_row    (nxt_row),
        .hit_left   (hit_left),
        .hit_top    (hit_top),
        .hit_right  (hit_right),
        .hit_bottom (hit_bottom)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q   <= CW'(1);
            row_q   <= CW'(1);
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= adv && tail;
            if (start_ok) begin
                col_q   <= CW'(1);
                row_q   <= CW'(1);
                valid_q <= 1'b1;
            end else if (adv) begin
                if (tail) begin
                    valid_q <= 1'b0;
                end else begin
                    col_q <= nxt_col;
                    row_q <= nxt_row;
                end
            end
        end
    end

    zz_lin_addr #(.BLK(BLK), .CW(CW), .AW(AW)) u_lin (
        .col (col_q),
        .row (row_q),
        .lin (addr_lin)
    );

    assign addr_valid = valid_q;
    assign addr_col   = col_q;
    assign addr_row   = row_q;
    assign addr_last  = valid_q && tail;
    assign scan_done  = done_q;

endmodule

// File: rtl/zz_scan_chk.sv
module zz_scan_chk #(
    parameter int BLK = 8,
    parameter int CW  = $clog2(BLK + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_start,
    input logic          addr_ready,
    input logic          addr_valid,
    input logic [CW-1:0] addr_col,
    input logic [CW-1:0] addr_row,
    input logic          addr_last,
    input logic          scan_done
);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr_col)
            && $stable(addr_row) && $stable(addr_last));

    // R9
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (addr_col >= CW'(1)) && (addr_col <= CW'(BLK))
            && (addr_row >= CW'(1)) && (addr_row <= CW'(BLK)));

    // R9
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && addr_ready && !addr_last |=> addr_valid
            && (addr_col != $past(addr_col) || addr_row != $past(addr_row)));

    // R6
    last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid && addr_col == CW'(BLK) && addr_row == CW'(BLK));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !addr_valid && $past(addr_last && addr_ready));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid && scan_start |=> addr_valid
            && addr_col == CW'(1) && addr_row == CW'(1));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready && scan_start |=> addr_valid
            && $stable(addr_col) && $stable(addr_row));

endmodule

bind zz_scan_gen zz_scan_chk #(.BLK(BLK), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_start (scan_start),
    .addr_ready (addr_ready),
    .addr_valid (addr_valid),
    .addr_col   (addr_col),
    .addr_row   (addr_row),
    .addr_last  (addr_last),
    .scan_done  (scan_done)
);

// File: tb/tb_zz_scan_gen.sv
module tb_zz_scan_gen;

    localparam int BLK  = 8;
    localparam int CW   = 4;
    localparam int AW   = 6;
    localparam int NPIX = BLK * BLK;
    localparam int NCK  = 8;

    // checkpoint vectors: {index, col, row}
    localparam logic [15:0] CKPT [NCK] = '{
        {8'd0,  4'd1, 4'd1},
        {8'd1,  4'd2, 4'd1},
        {8'd2,  4'd1, 4'd2},
        {8'd3,  4'd1, 4'd3},
        {8'd28, 4'd8, 4'd1},
        {8'd35, 4'd1, 4'd8},
        {8'd36, 4'd2, 4'd8},
        {8'd63, 4'd8, 4'd8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ready = 1'b0;
    logic          valid, last, done;
    logic [CW-1:0] col, row;
    logic [AW-1:0] lin;

    int n_chk = 0;
    int n_bad = 0;
    int exp_c [NPIX];
    int exp_r [NPIX];
    int got_c [NPIX];
    int got_r [NPIX];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    zz_scan_gen #(.BLK(BLK), .CW(CW), .AW(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_start (start),
        .addr_ready (ready),
        .addr_valid (valid),
        .addr_col   (col),
        .addr_row   (row),
        .addr_lin   (lin),
        .addr_last  (last),
        .scan_done  (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_order();
        int n = 0;
        for (int s = 0; s <= 2 * BLK - 2; s++) begin
            if (s % 2 == 1) begin
                for (int c = (s < BLK ? s : BLK - 1); c >= 0 && s - c < BLK; c--) begin
                    exp_c[n] = c + 1; exp_r[n] = s - c + 1; n++;
                end
            end else begin
                for (int r = (s < BLK ? s : BLK - 1); r >= 0 && s - r < BLK; r--) begin
                    exp_c[n] = s - r + 1; exp_r[n] = r + 1; n++;
                end
            end
        end
    endtask

    // mode 0: always ready, 1: pseudo-random, 2: ready one cycle in three
    task automatic run_scan(input int mode, input bit poke);
        int k = 0;
        int cyc = 0;
        bit stall = 0;
        bit got_done = 0;
        int pc = 0, pr = 0;
        logic [NPIX-1:0] seen = '0;
        @(negedge clk); start = 1'b1; ready = 1'b0;
        @(negedge clk); start = 1'b0;
        // R2 R11
        chk(valid && col == 1 && row == 1 && lin == 0, "R2 R11 start at origin", {col, row}, 8'h11);
        while (cyc < 3000) begin
            cyc++;
            if (done) begin
                got_done = 1;
                chk(!valid, "R7 valid low with done", valid, 0);
                chk(k == NPIX, "R3 address count", k, NPIX);
                break;
            end
            if (stall) chk(valid && col == pc && row == pr, "R4 hold under stall", {col, row}, {pc[3:0], pr[3:0]});
            if (valid) begin
                chk(lin == (row - 1) * BLK + (col - 1), "R5 linear address", lin, (row - 1) * BLK + (col - 1));
                chk(last == (k == NPIX - 1), "R6 last flag", last, (k == NPIX - 1));
                chk(col >= 1 && col <= BLK && row >= 1 && row <= BLK, "R9 range", {col, row}, 0);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: ready = 1'b1;
                1: ready = lfsr[0] | lfsr[3];
                default: ready = (cyc % 3 == 0);
            endcase
            start = poke && valid && (k == 10 || k == 40);
            if (valid && ready) begin
                if (k < NPIX) begin
                    chk(col == exp_c[k] && row == exp_r[k], "R3 R8 zigzag order", {col, row}, {exp_c[k][3:0], exp_r[k][3:0]});
                    chk(!seen[lin], "R10 no repeat", lin, 0);
                    seen[lin] = 1'b1;
                    got_c[k] = col; got_r[k] = row;
                end
                k++;
            end
            stall = valid && !ready;
            pc = col; pr = row;
            @(negedge clk);
        end
        start = 1'b0; ready = 1'b0;
        chk(got_done, "R7 done seen", got_done, 1);
        @(negedge clk);
        chk(!done && !valid, "R7 done single cycle", done, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        build_order();
        repeat (3) @(negedge clk);
        // R1
        chk(!valid && !last && !done, "R1 reset state", {valid, last, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid && !last && !done, "R1 after reset release", {valid, last, done}, 0);

        run_scan(0, 1'b0);
        // checkpoint table
        for (int i = 0; i < NCK; i++) begin
            chk(got_c[CKPT[i][15:8]] == CKPT[i][7:4] && got_r[CKPT[i][15:8]] == CKPT[i][3:0],
                "R3 checkpoint", {got_c[CKPT[i][15:8]][3:0], got_r[CKPT[i][15:8]][3:0]}, CKPT[i][7:0]);
        end

        run_scan(1, 1'b1);   // R8 R11 random stall with starts while busy
        run_scan(2, 1'b1);   // R4 R8 heavy stall

        // R8 directed: start during stall leaves the coordinate in place
        @(negedge clk); start = 1'b1; ready = 1'b0;
        @(negedge clk); start = 1'b0; ready = 1'b1;
        @(negedge clk); ready = 1'b0;
        chk(valid && col == 2 && row == 1, "R8 before busy start", {col, row}, 8'h21);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(valid && col == 2 && row == 1, "R8 busy start ignored", {col, row}, 8'h21);
        ready = 1'b1;
        @(negedge clk); ready = 1'b0;
        chk(valid && col == 1 && row == 2, "R8 order kept", {col, row}, 8'h12);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule